// File: doc/BRIEF.md
# Shared-Period Six-Channel PWM with Dead-Band Pair

This block produces six pulse-width-modulated outputs from one 16-bit period counter. The counter advances on a clock-enable tick, so the PWM clock may be any integer fraction of the system clock. Each channel compares the shared count against its own 16-bit duty value. The output is high while the count is below that duty value.

Channel 0 drives a complementary pair instead of a single line. The pair has a programmable non-overlap delay of 0 to 15 ticks and four output modes. A period-end pulse marks each wrap of the counter, and software uses it to pace register updates.

Period, duty, dead-time and mode inputs are shadowed. They reach the active set only at a wrap, so every period runs on one consistent configuration. Dropping the run input parks the whole block. While run is low the outputs are low, the counter is held at zero, and the shadows follow the inputs.

Top module: `shared_pwm_bank`

## Requirements
- R1: While reset is applied, every output is low and stays low until run is raised.
- R2: With run high, the counter advances by one on each clock where tick is high, goes from the period value back to 0, and holds when tick is low.
- R3: period_end is high for exactly one clock, in the clock that follows the edge at which the counter wrapped from the period value to 0.
- R4: Period, duty (channel i at duty_in bits 16i+15..16i), dead-time and mode inputs are copied into the active set only at a wrap edge or at an edge while run is low. Changes in mid-period have no effect until the next wrap.
- R5: Channel i compares the count held between edges k and k+1 against its duty value (count below duty). The result appears on its output after edge k+2. A duty of 0 gives a constant low and a duty above the period gives a constant high. Channels 1 to 5 drive ch_aux bits 0 to 4.
- R6: In mode 0 (mode_in = 2'd0), ch0_p follows the channel 0 compare and ch0_n follows its inverse. Each output rises only once dead_in ticks have been counted since the compare last changed. A level shorter than the dead time never appears, and the two outputs are never high together.
- R7: In mode 3 (mode_in = 2'd3), both outputs are the inverse of their mode 0 values, so they are never low together while run is high.
- R8: In mode 1 (mode_in = 2'd1), both outputs carry the channel 0 compare in phase with no dead time. In mode 2 (mode_in = 2'd2), ch0_p carries the compare and ch0_n stays low.
- R9: From the first edge after run goes low, all outputs, period_end included, are low and the counter sits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | PWM clock enable; one count per high clock |
| run | input | 1 | Run enable; low parks the block with outputs low |
| period_in | input | 16 | Shadow period value (last count before wrap) |
| duty_in | input | 96 | Shadow duty values, channel i at bits 16i+15..16i |
| dead_in | input | 4 | Shadow non-overlap delay in ticks |
| mode_in | input | 2 | Shadow output mode of the channel 0 pair |
| ch0_p | output | 1 | Channel 0 positive output |
| ch0_n | output | 1 | Channel 0 negative output |
| ch_aux | output | 5 | Channels 1 to 5 |
| period_end | output | 1 | One-clock pulse after each wrap |

## Verification
The duty set mixes a duty of 0, duties inside the period, a duty equal to the period and duties above it. This separates the plain compare from both saturating ends and catches an off-by-one at the period value. Dead time is tried both longer and shorter than the channel 0 high level, so suppression of a short pulse shows apart from a plain delay. All four modes are run on the same waveform. A mid-period change of period and duties, a tick that is high only one clock in three, and a run drop in mid-period each expose a different fault: an early shadow load, counting on every clock, or leftover output state.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic [1:0] {
    OM_COMP     = 2'd0,
    OM_INPHASE  = 2'd1,
    OM_POSONLY  = 2'd2,
    OM_COMP_INV = 2'd3
  } out_mode_e;
endpackage

// File: rtl/spwm_timebase.sv
module spwm_timebase
  import spwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 6,
  parameter int DTW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic [CW-1:0]      period_in,
  input  logic [NCH*CW-1:0]  duty_in,
  input  logic [DTW-1:0]     dead_in,
  input  logic [1:0]         mode_in,
  output logic [CW-1:0]      cnt,
  output logic [NCH*CW-1:0]  duty_act,
  output logic [DTW-1:0]     dead_act,
  output out_mode_e          mode_act,
  output logic               period_end
);
  logic [CW-1:0]     cnt_q, cnt_d, per_q, per_d;
  logic [NCH*CW-1:0] duty_q, duty_d;
  logic [DTW-1:0]    dead_q, dead_d;
  out_mode_e         mode_q, mode_d;
  logic              pe_q, pe_d;
  logic              at_top, wrap, load;

  assign at_top = (cnt_q == per_q);
  assign wrap   = run & tick & at_top;
  assign load   = wrap | ~run;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (tick)
      cnt_d = at_top ? '0 : cnt_q + 1'b1;
    pe_d   = wrap;
    per_d  = load ? period_in : per_q;
    duty_d = load ? duty_in : duty_q;
    dead_d = load ? dead_in : dead_q;
    mode_d = load ? out_mode_e'(mode_in) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      dead_q <= '0;
      mode_q <= OM_COMP;
      pe_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      dead_q <= dead_d;
      mode_q <= mode_d;
      pe_q   <= pe_d;
    end
  end

  assign cnt        = cnt_q;
  assign duty_act   = duty_q;
  assign dead_act   = dead_q;
  assign mode_act   = mode_q;
  assign period_end = pe_q;

  // R2: count never passes the active period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);
  // R2: no tick, no count
  p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));
  // R3: the end pulse coincides with a zero count
  p_pe_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pe_q |-> (cnt_q == '0));
  // R4: active set is frozen away from a wrap
  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(tick && at_top)) |=> ($stable(per_q) && $stable(duty_q) && $stable(dead_q)));
endmodule

// File: rtl/spwm_cmp.sv
module spwm_cmp #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] duty,
  output logic          lvl
);
  logic lvl_q, lvl_d;

  always_comb lvl_d = run & (cnt < duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign lvl = lvl_q;

  // R5: zero duty never produces a high level
  p_zero_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> !lvl_q);
endmodule

// File: rtl/spwm_deadband.sv
module spwm_deadband
  import spwm_pkg::*;
#(
  parameter int DTW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           run,
  input  logic           lvl,
  input  logic [DTW-1:0] dead,
  input  out_mode_e      mode,
  output logic           pos,
  output logic           neg
);
  localparam logic [DTW-1:0] AGE_MAX = {DTW{1'b1}};

  logic [DTW-1:0] age_q, age_d;
  logic           last_q;
  logic           pos_q, neg_q, pos_d, neg_d;
  logic           settled;

  always_comb begin
    if (lvl != last_q)
      age_d = '0;
    else if (tick && (age_q != AGE_MAX))
      age_d = age_q + 1'b1;
    else
      age_d = age_q;
    settled = (age_d >= dead);
    unique case (mode)
      OM_COMP: begin
        pos_d = lvl & settled;
        neg_d = ~lvl & settled;
      end
      OM_INPHASE: begin
        pos_d = lvl;
        neg_d = lvl;
      end
      OM_POSONLY: begin
        pos_d = lvl;
        neg_d = 1'b0;
      end
      default: begin
        pos_d = ~(lvl & settled);
        neg_d = ~(~lvl & settled);
      end
    endcase
    pos_d = pos_d & run;
    neg_d = neg_d & run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      last_q <= 1'b0;
      pos_q  <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      age_q  <= age_d;
      last_q <= lvl;
      pos_q  <= pos_d;
      neg_q  <= neg_d;
    end
  end

  assign pos = pos_q;
  assign neg = neg_q;

  // R6: complementary pair never high together
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(mode) == OM_COMP) |-> !(pos_q && neg_q));
  // R7: inverted pair never low together
  p_inv_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(mode) == OM_COMP_INV) |-> (pos_q || neg_q));
  // R8: positive-only mode keeps the negative line low
  p_posonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == OM_POSONLY) |-> !neg_q);
endmodule

// File: rtl/shared_pwm_bank.sv
module shared_pwm_bank
  import spwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 6,
  parameter int DTW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic [CW-1:0]     period_in,
  input  logic [NCH*CW-1:0] duty_in,
  input  logic [DTW-1:0]    dead_in,
  input  logic [1:0]        mode_in,
  output logic              ch0_p,
  output logic              ch0_n,
  output logic [NCH-2:0]    ch_aux,
  output logic              period_end
);
  localparam int NAUX = NCH - 1;

  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic [CW-1:0]     cnt;
  logic [NCH*CW-1:0] duty_act;
  logic [DTW-1:0]    dead_act;
  out_mode_e         mode_act;
  logic [NCH-1:0]    lvl;
  logic [NAUX-1:0]   aux_q, aux_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  spwm_timebase #(.CW(CW), .NCH(NCH), .DTW(DTW)) u_tb (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .run(run),
    .period_in(period_in), .duty_in(duty_in), .dead_in(dead_in),
    .mode_in(mode_in), .cnt(cnt), .duty_act(duty_act),
    .dead_act(dead_act), .mode_act(mode_act), .period_end(period_end)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    spwm_cmp #(.CW(CW)) u_cmp (
      .clk(clk), .rst_n(rst_i_n), .run(run), .cnt(cnt),
      .duty(duty_act[g*CW +: CW]), .lvl(lvl[g])
    );
  end

  spwm_deadband #(.DTW(DTW)) u_db (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .run(run), .lvl(lvl[0]),
    .dead(dead_act), .mode(mode_act), .pos(ch0_p), .neg(ch0_n)
  );

  always_comb aux_d = run ? lvl[NCH-1:1] : '0;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) aux_q <= '0;
    else          aux_q <= aux_d;
  end
  assign ch_aux = aux_q;

  // R9: dropping run clears every output at the next edge
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !run |=> (!ch0_p && !ch0_n && ch_aux == '0 && !period_end));
endmodule

// File: tb/sim_shared_pwm_bank.sv
module sim_shared_pwm_bank;
  localparam int CW = 16, NCH = 6, DTW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, run = 1'b0;
  logic [CW-1:0] period_in = '0;
  logic [NCH*CW-1:0] duty_in = '0;
  logic [DTW-1:0] dead_in = '0;
  logic [1:0] mode_in = '0;
  logic ch0_p, ch0_n, period_end;
  logic [NCH-2:0] ch_aux;

  always #2 clk = ~clk;

  shared_pwm_bank #(.CW(CW), .NCH(NCH), .DTW(DTW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .period_in(period_in), .duty_in(duty_in), .dead_in(dead_in),
    .mode_in(mode_in), .ch0_p(ch0_p), .ch0_n(ch0_n),
    .ch_aux(ch_aux), .period_end(period_end)
  );

  int total = 0, bad = 0, cyc = 0, tdiv = 1, tph = 0;
  string cur_req = "R5";
  logic [7:0] exp_q[$];
  string req_q[$];

  // reference built from the requirements
  logic [CW-1:0] m_cnt, m_per;
  logic [CW-1:0] m_dty[NCH];
  logic [DTW-1:0] m_dead, m_age, age_d;
  logic [1:0] m_mode;
  logic [NCH-1:0] m_cmp;
  logic m_last, s0, s1, ok, p, n, pe, c;
  logic [NCH-2:0] aux;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_per = '0; m_dead = '0; m_age = '0; m_mode = '0;
      m_cmp = '0; m_last = 1'b0; s0 = 1'b0; s1 = 1'b0;
      for (int i = 0; i < NCH; i++) m_dty[i] = '0;
    end else begin
      if (s1) begin
        c = m_cmp[0];
        if (c != m_last) age_d = '0;
        else if (tick && m_age != 4'hF) age_d = m_age + 1'b1;
        else age_d = m_age;
        ok = (age_d >= m_dead);
        case (m_mode)
          2'd0: begin p = c & ok; n = ~c & ok; end
          2'd1: begin p = c; n = c; end
          2'd2: begin p = c; n = 1'b0; end
          default: begin p = ~(c & ok); n = ~(~c & ok); end
        endcase
        p = p & run; n = n & run;
        aux = run ? m_cmp[NCH-1:1] : '0;
        pe = run & tick & (m_cnt == m_per);
        m_last = c; m_age = age_d;
        for (int i = 0; i < NCH; i++) m_cmp[i] = run & (m_cnt < m_dty[i]);
        if (!run) m_cnt = '0;
        else if (tick) m_cnt = (m_cnt == m_per) ? '0 : m_cnt + 1'b1;
        if (!run || pe) begin
          m_per = period_in; m_dead = dead_in; m_mode = mode_in;
          for (int i = 0; i < NCH; i++) m_dty[i] = duty_in[i*CW +: CW];
        end
        exp_q.push_back({p, n, aux, pe});
        req_q.push_back(cur_req);
      end
      s1 = s0; s0 = 1'b1;
    end
  end

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e, a;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      a = {ch0_p, ch0_n, ch_aux, period_end};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: outputs {p,n,aux,pe} actual=%b expected=%b at cycle %0d",
                 r, a, e, cyc);
      end
    end
  end

  // tick generator and watchdog
  always @(negedge clk) begin
    tph = (tph + 1) % tdiv;
    tick = (tph == 0);
  end
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
    end
  end

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic set_duty(input logic [CW-1:0] d0, d1, d2, d3, d4, d5);
    duty_in = {d5, d4, d3, d2, d1, d0};
  endtask

  task automatic check_idle(input string r);
    total++;
    if ({ch0_p, ch0_n, ch_aux, period_end} !== 8'h00) begin
      bad++;
      $display("FAIL %s: idle outputs actual=%b expected=00000000",
               r, {ch0_p, ch0_n, ch_aux, period_end});
    end
  endtask

  initial begin
    wait_cyc(3);
    check_idle("R1");
    rst_n = 1'b1;
    wait_cyc(4);
    check_idle("R1");
    // duty 0, inside, equal to period, above period
    cur_req = "R2 R3 R5";
    period_in = 16'd9;
    set_duty(16'd4, 16'd0, 16'd5, 16'd9, 16'd10, 16'd200);
    dead_in = 4'd0; mode_in = 2'd0;
    run = 1'b1;
    wait_cyc(35);
    // dead time longer than nothing, then a short high level
    cur_req = "R6";
    dead_in = 4'd3;
    wait_cyc(30);
    set_duty(16'd2, 16'd0, 16'd5, 16'd9, 16'd10, 16'd200);
    wait_cyc(30);
    set_duty(16'd6, 16'd1, 16'd5, 16'd9, 16'd10, 16'd200);
    cur_req = "R8";
    mode_in = 2'd1;
    wait_cyc(25);
    mode_in = 2'd2;
    wait_cyc(25);
    cur_req = "R7";
    mode_in = 2'd3;
    wait_cyc(25);
    // mid-period change must wait for the wrap
    cur_req = "R4";
    mode_in = 2'd0; dead_in = 4'd1;
    wait_cyc(3);
    period_in = 16'd5;
    set_duty(16'd3, 16'd2, 16'd5, 16'd6, 16'd1, 16'd4);
    wait_cyc(30);
    // slow PWM clock
    cur_req = "R2 R6";
    tdiv = 3; dead_in = 4'd2;
    wait_cyc(80);
    tdiv = 1;
    // drop run mid-period
    cur_req = "R9";
    wait_cyc(4);
    run = 1'b0;
    wait_cyc(2);
    check_idle("R9");
    wait_cyc(5);
    check_idle("R9");
    run = 1'b1;
    cur_req = "R5 R9";
    wait_cyc(30);
    wait_cyc(2);
    report();
  end
endmodule